// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the system clock into a one-cycle enable strobe at a programmable, fractional rate, for use by serial transmit and receive logic that advances one bit period (or one oversampling slot) per strobe. Two programmed values set the rate. An integer divider first reduces the clock by `scale + 1`. On every divided event a 17-bit phase accumulator adds `step`, and the carry out of the accumulator is the strobe. The resulting rate is `f_clk / (scale + 1) * step / 2^17`, which gives fine fractional control without a wide divider.

Both values arrive packed in one 32-bit control word. Every scale/step pair in range must be honoured exactly, because the value that configures the block picks the pair with the smallest error against a target rate. Any change to the packed fields restarts the divider and the accumulator, so the first strobe after a change already follows the new rate.

Top module: `baud_tick_gen`

## Requirements
- R1: The control word carries `step` in bits 15:0 and `scale` in bits 27:16. Bits 31:28 are ignored: changing only them causes no restart and no change in the strobe pattern.
- R2: While enabled, an accumulation event occurs once every `scale + 1` enabled clock edges. With `scale` = 0 there is an event on every enabled edge.
- R3: Each event adds `step` to a 17-bit phase whose remainder is kept. After m events since the last restart, the strobe has fired exactly floor(m * step / 2^17) times. It fires in the cycle that follows the clock edge of the event that produced the carry.
- R4: `tick` is never high for two consecutive cycles.
- R5: With `step` = 0, `tick` never rises.
- R6: A change in bits 27:0 of the control word is taken at the next clock edge. That edge clears the divider and the phase and holds `tick` low in the following cycle. The first event comes `scale + 1` enabled edges after that edge.
- R7: While `en` is low, `tick` is low and the divider and phase hold their values. Counting resumes where it stopped once `en` returns high.
- R8: During and after reset, `tick` is low and the stored configuration is zero, which means `step` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; gates counting and the strobe |
| ctrl_word | input | 32 | Packed configuration: step in [15:0], scale in [27:16] |
| tick | output | 1 | One-cycle rate strobe |

## Verification
Directed patterns cover three cases. `scale` = 0 with `step` = 2^15 must give a strobe exactly every fourth cycle, which separates a correct carry from an off-by-one divider. The maximum `step` shows that strobes never merge. The maximum `scale` checks the full width of the divider compare. A zero `step` must produce silence, and toggling `en` mid-period must resume without losing phase. A rewrite partway through a period must restart cleanly, while a rewrite of only the unused top bits must not, which tells a field-wise compare from a whole-word compare. Random scale/step pairs are checked cycle by cycle against the floor formula, and each segment's strobe total is checked as well. This catches a cleared remainder or a wrong accumulator width, both of which drift only over many events.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int SCALE_W   = 12,
  parameter int STEP_W    = 16,
  parameter int SCALE_LSB = 16,
  parameter int CTRL_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              tick
);
  localparam int ACC_W = STEP_W + 1;
  localparam int CFG_W = SCALE_LSB + SCALE_W;

  logic [CFG_W-1:0]   cfg_q;
  logic [SCALE_W-1:0] cnt_q;
  logic [ACC_W-1:0]   acc_q;
  logic               tick_q;
  logic [ACC_W:0]     sum;
  logic               unused_hi;

  wire                changed = ctrl_word[CFG_W-1:0] != cfg_q;
  wire [SCALE_W-1:0]  scale_q = cfg_q[CFG_W-1:SCALE_LSB];
  wire [STEP_W-1:0]   step_q  = cfg_q[STEP_W-1:0];
  wire                wrap    = cnt_q == scale_q;

  assign sum       = {1'b0, acc_q} + {{(ACC_W+1-STEP_W){1'b0}}, step_q};
  assign tick      = tick_q & en;
  assign unused_hi = ^ctrl_word[CTRL_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (changed) begin
      cfg_q  <= ctrl_word[CFG_W-1:0];
      cnt_q  <= '0;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (en) begin
      if (wrap) begin
        cnt_q  <= '0;
        acc_q  <= sum[ACC_W-1:0];
        tick_q <= sum[ACC_W];
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int STEP_W    = 16,
  parameter int SCALE_W   = 12,
  parameter int SCALE_LSB = 16,
  parameter int CTRL_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              tick
);
  localparam int CFG_W = SCALE_LSB + SCALE_W;
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  p_gated_by_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);

  p_zero_step_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && $past(ctrl_word[STEP_W-1:0]) == '0) |-> !tick);

  p_reload_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 &&
     $past(ctrl_word[CFG_W-1:0]) != $past(ctrl_word[CFG_W-1:0], 2)) |-> !tick);

  p_reset_low_r8: assert property (@(posedge clk)
    !rst_n |-> !tick);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(
  .STEP_W(STEP_W), .SCALE_W(SCALE_W), .SCALE_LSB(SCALE_LSB), .CTRL_W(CTRL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ctrl_word(ctrl_word), .tick(tick)
);

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] ctrl = '0;
  logic        tick;

  int n_cmp = 0;
  int n_bad = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string cur_req = "R8";

  longint unsigned cfg = 0, cyc = 0;
  bit exp_q = 1'b0;
  int seg_ticks = 0;

  always #10 clk = ~clk;

  baud_tick_gen dut (.clk(clk), .rst_n(rst_n), .en(en), .ctrl_word(ctrl), .tick(tick));

  function automatic bit carry_at(longint unsigned m, longint unsigned t);
    return ((m * t) >> 17) != (((m - 1) * t) >> 17);
  endfunction

  function automatic longint unsigned total_ticks(longint unsigned c, longint unsigned s,
                                                   longint unsigned t);
    return ((c / (s + 1)) * t) >> 17;
  endfunction

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    longint unsigned s, t;
    if (!rst_n) begin
      cfg = 0; cyc = 0; exp_q = 1'b0;
    end else if ({36'd0, ctrl[27:0]} != cfg) begin
      cfg = {36'd0, ctrl[27:0]}; cyc = 0; exp_q = 1'b0;
    end else if (en) begin
      cyc++;
      s = (cfg >> 16) & 64'hfff;
      t = cfg & 64'hffff;
      exp_q = (cyc % (s + 1) == 0) ? carry_at(cyc / (s + 1), t) : 1'b0;
    end else begin
      exp_q = 1'b0;
    end
    #5;
    if (tick) seg_ticks++;
    if (chk_on) check(cur_req, tick, exp_q & en);
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic seg_total(string req);
    longint unsigned s, t;
    s = (cfg >> 16) & 64'hfff;
    t = cfg & 64'hffff;
    check(req, seg_ticks, total_ticks(cyc, s, t));
  endtask

  task automatic load(int unsigned scale, int unsigned step, int unsigned hi);
    @(negedge clk);
    ctrl = {hi[3:0], scale[11:0], step[15:0]};
    seg_ticks = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1207));
    run(2);
    #5;
    check("R8", tick, 0);
    ctrl = 32'h0000_8000;
    run(2);
    check("R8", tick, 0);
    @(negedge clk);
    ctrl = '0;
    rst_n = 1'b1;
    en = 1'b1;
    chk_on = 1'b1;
    cur_req = "R8";
    run(20);

    cur_req = "R3";
    load(0, 32768, 0); run(101); seg_total("R3");
    cur_req = "R4";
    load(0, 65535, 0); run(300); seg_total("R4");
    cur_req = "R2";
    load(4095, 65535, 0); run(17000); seg_total("R2");
    cur_req = "R5";
    load(3, 0, 0); run(500); seg_total("R5");

    cur_req = "R7";
    load(2, 40000, 0); run(50);
    en = 1'b0; run(31);
    en = 1'b1; run(200); seg_total("R7");

    cur_req = "R1";
    load(1, 45000, 0); run(37);
    ctrl[31:28] = 4'ha; run(50);
    ctrl[31:28] = 4'h5; run(200); seg_total("R1");

    cur_req = "R6";
    load(9, 50000, 0); run(13);
    load(9, 50001, 0); run(400); seg_total("R6");
    load(6, 50001, 0); run(3);
    load(6, 60000, 0); run(400); seg_total("R6");

    for (int i = 0; i < 24; i++) begin
      int unsigned sc, st;
      sc = (i % 4 == 0) ? $urandom % 300 : $urandom % 16;
      st = $urandom % 65536;
      cur_req = "R3";
      load(sc, st, $urandom % 16);
      if (i % 5 == 0) begin
        run(200); en = 1'b0; run(7); en = 1'b1;
      end
      run(1500);
      seg_total("R3");
    end

    chk_on = 1'b0;
    run(2);
    finish_run();
  end
endmodule